// File: doc/BRIEF.md
# Dual Compare-and-Swap Sequencer

This block carries out an atomic-style double compare-and-swap as a bus master. A caller supplies two memory addresses, an operand size (16-bit or 32-bit) and a 12-bit select word. The select word picks four entries of an eight-entry data register file: two compare registers and two update registers. The block reads both memory locations and compares each value with its compare register. It stores both update values only when both comparisons succeed. It then hands the two observed memory values back to the compare registers and reports compare-style condition flags.

Each memory access uses a single request/acknowledge handshake, with one access outstanding at a time. In 32-bit mode, two operands that are the two halves of one 8-byte-aligned doubleword are handled as a single 64-bit read and, on success, a single 64-bit write. The register file is read as a flat vector when the operation starts. It is written through two write ports in one final cycle, and that cycle also presents the flags.

Top module: `dcas_seq`

## Requirements
- R1: Select word fields: bits 11:9 pick compare register A, bits 8:6 compare register B, bits 5:3 update register A, bits 2:0 update register B. Register k occupies bits 32k+31:32k of `rf_i`.
- R2: Both locations are read before any write. Location A (`addr1_i`) receives update A and location B receives update B only when both locations equal their compare values. Otherwise no write is issued.
- R3: In the final cycle, write port 1 loads compare register A with the value read from location A, and write port 2 loads compare register B with the value read from location B. When both indices are the same, port 2 takes priority, so that register ends up holding location B's value.
- R4: In 16-bit mode (`long_i`=0), accesses are 16-bit and only the low halves are compared and written. The write-back value keeps the upper 16 bits of the compare register and replaces the low 16 bits.
- R5: `flags_o` = {N,Z,V,C} of (memory − compare) at the operand size. Pair A is used if it differs; otherwise pair B is used. C is the unsigned borrow and V is the signed overflow.
- R6: In 32-bit mode, when one address is 8-byte aligned and the other is that address plus 4, the block issues one 64-bit read at the aligned address and, on success, one 64-bit write. The lower-addressed word sits in bits 63:32.
- R7: `bus_req_o` is held with stable address, direction and size until `bus_ack_i`. Size codes: 0 = 16-bit, 1 = 32-bit, 2 = 64-bit. Data is right-aligned on `bus_wdata_o` and `bus_rdata_i`.
- R8: Register write-back, flags and `done_o` appear in one single-cycle final state after the last bus access, with no bus request in that cycle. `start_i` is ignored while an operation is in progress.
- R9: After reset, the block is idle, with no bus request, no write-back enable and no `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (accepted only when idle) |
| long_i | input | 1 | 1 = 32-bit operands, 0 = 16-bit |
| addr1_i | input | AW | Address of location A |
| addr2_i | input | AW | Address of location B |
| sel_i | input | 4*log2(NREG) | Register select word |
| rf_i | input | NREG*32 | Flat view of the data register file |
| bus_req_o | output | 1 | Bus access request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_size_o | output | 2 | Access size code |
| bus_addr_o | output | AW | Access address |
| bus_wdata_o | output | 64 | Write data, right-aligned |
| bus_ack_i | input | 1 | Access completed |
| bus_rdata_i | input | 64 | Read data, valid with acknowledge |
| wb1_en_o | output | 1 | Write port 1 enable |
| wb1_idx_o | output | log2(NREG) | Write port 1 register index |
| wb1_data_o | output | 32 | Write port 1 data |
| wb2_en_o | output | 1 | Write port 2 enable (wins on equal index) |
| wb2_idx_o | output | log2(NREG) | Write port 2 register index |
| wb2_data_o | output | 32 | Write port 2 data |
| done_o | output | 1 | Final-cycle strobe |
| flags_o | output | 4 | {N,Z,V,C} compare flags |

## Verification
The two register write-back ports fire in the same final cycle as the flag output. When the select word names one register as both compare registers, the two ports collide on the same index. The bench provokes this with a failing 32-bit attempt whose two compare indices are equal. It applies port 1 and then port 2 to its own register model, and requires the register to end up holding location B's value. Flags from that same cycle are judged against an independent signed/unsigned subtraction model.

// File: rtl/dcas_pkg.sv
package dcas_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD1,
        ST_RD2,
        ST_WR1,
        ST_WR2,
        ST_FIN
    } dcas_state_e;

    localparam logic [1:0] SZ_HALF = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd1;
    localparam logic [1:0] SZ_DBL  = 2'd2;
endpackage

// File: rtl/dcas_pair_detect.sv
module dcas_pair_detect #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] a1_i,
    input  logic [AW-1:0] a2_i,
    input  logic          long_i,
    output logic          fused_o,
    output logic          swap_o
);
    logic fwd, rev;

    always_comb begin
        fwd     = (a1_i[2:0] == 3'b000) && (a2_i == a1_i + AW'(4));
        rev     = (a2_i[2:0] == 3'b000) && (a1_i == a2_i + AW'(4));
        fused_o = long_i && (fwd || rev);
        swap_o  = long_i && rev && !fwd;
    end
endmodule

// File: rtl/dcas_flag_calc.sv
module dcas_flag_calc (
    input  logic [31:0] mem_i,
    input  logic [31:0] cmp_i,
    input  logic        long_i,
    output logic [3:0]  nzvc_o
);
    logic [31:0] diff;
    logic        msb_d, msb_m, msb_c, zero, borrow;

    always_comb begin
        diff = mem_i - cmp_i;
        if (long_i) begin
            msb_d  = diff[31];
            msb_m  = mem_i[31];
            msb_c  = cmp_i[31];
            zero   = (diff == 32'h0);
            borrow = (mem_i < cmp_i);
        end else begin
            msb_d  = diff[15];
            msb_m  = mem_i[15];
            msb_c  = cmp_i[15];
            zero   = (diff[15:0] == 16'h0);
            borrow = (mem_i[15:0] < cmp_i[15:0]);
        end
        nzvc_o = {msb_d, zero, (msb_m ^ msb_c) & (msb_d ^ msb_m), borrow};
    end
endmodule

// File: rtl/dcas_seq.sv
module dcas_seq
    import dcas_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NREG = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      long_i,
    input  logic [AW-1:0]             addr1_i,
    input  logic [AW-1:0]             addr2_i,
    input  logic [4*$clog2(NREG)-1:0] sel_i,
    input  logic [NREG*32-1:0]        rf_i,
    output logic                      bus_req_o,
    output logic                      bus_we_o,
    output logic [1:0]                bus_size_o,
    output logic [AW-1:0]             bus_addr_o,
    output logic [63:0]               bus_wdata_o,
    input  logic                      bus_ack_i,
    input  logic [63:0]               bus_rdata_i,
    output logic                      wb1_en_o,
    output logic [$clog2(NREG)-1:0]   wb1_idx_o,
    output logic [31:0]               wb1_data_o,
    output logic                      wb2_en_o,
    output logic [$clog2(NREG)-1:0]   wb2_idx_o,
    output logic [31:0]               wb2_data_o,
    output logic                      done_o,
    output logic [3:0]                flags_o
);
    localparam int IDXW = $clog2(NREG);

    typedef struct packed {
        dcas_state_e     st;
        logic            lng;
        logic            fused;
        logic            swap;
        logic [AW-1:0]   a1;
        logic [AW-1:0]   a2;
        logic [IDXW-1:0] ic1;
        logic [IDXW-1:0] ic2;
        logic [31:0]     c1;
        logic [31:0]     c2;
        logic [31:0]     u1;
        logic [31:0]     u2;
        logic [31:0]     m1;
        logic [31:0]     m2;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    function automatic logic [31:0] fit(input logic [31:0] v, input logic l);
        return l ? v : {16'h0, v[15:0]};
    endfunction

    // R1: select word fields
    logic [IDXW-1:0] f_c1, f_c2, f_u1, f_u2;
    assign f_c1 = sel_i[4*IDXW-1 -: IDXW];
    assign f_c2 = sel_i[3*IDXW-1 -: IDXW];
    assign f_u1 = sel_i[2*IDXW-1 -: IDXW];
    assign f_u2 = sel_i[IDXW-1:0];

    logic in_fused, in_swap;
    dcas_pair_detect #(.AW(AW)) u_pair (
        .a1_i   (addr1_i),
        .a2_i   (addr2_i),
        .long_i (long_i),
        .fused_o(in_fused),
        .swap_o (in_swap)
    );

    logic [31:0] rd_hi, rd_lo;
    assign rd_hi = bus_rdata_i[63:32];
    assign rd_lo = bus_rdata_i[31:0];

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctx_d.st    = ST_RD1;
                    ctx_d.lng   = long_i;
                    ctx_d.fused = in_fused;
                    ctx_d.swap  = in_swap;
                    ctx_d.a1    = addr1_i;
                    ctx_d.a2    = addr2_i;
                    ctx_d.ic1   = f_c1;
                    ctx_d.ic2   = f_c2;
                    ctx_d.c1    = rf_i[int'(f_c1)*32 +: 32];
                    ctx_d.c2    = rf_i[int'(f_c2)*32 +: 32];
                    ctx_d.u1    = rf_i[int'(f_u1)*32 +: 32];
                    ctx_d.u2    = rf_i[int'(f_u2)*32 +: 32];
                    ctx_d.m1    = 32'h0;
                    ctx_d.m2    = 32'h0;
                end
            end
            ST_RD1: begin
                if (bus_ack_i) begin
                    if (ctx_q.fused) begin
                        ctx_d.m1 = ctx_q.swap ? rd_lo : rd_hi;
                        ctx_d.m2 = ctx_q.swap ? rd_hi : rd_lo;
                        ctx_d.st = (ctx_d.m1 == ctx_q.c1 && ctx_d.m2 == ctx_q.c2)
                                   ? ST_WR1 : ST_FIN;
                    end else begin
                        ctx_d.m1 = fit(rd_lo, ctx_q.lng);
                        ctx_d.st = ST_RD2;
                    end
                end
            end
            ST_RD2: begin
                if (bus_ack_i) begin
                    ctx_d.m2 = fit(rd_lo, ctx_q.lng);
                    ctx_d.st = (ctx_q.m1 == fit(ctx_q.c1, ctx_q.lng) &&
                                ctx_d.m2 == fit(ctx_q.c2, ctx_q.lng)) ? ST_WR1 : ST_FIN;
                end
            end
            ST_WR1: begin
                if (bus_ack_i) ctx_d.st = ctx_q.fused ? ST_FIN : ST_WR2;
            end
            ST_WR2: begin
                if (bus_ack_i) ctx_d.st = ST_FIN;
            end
            ST_FIN:  ctx_d.st = ST_IDLE;
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q    <= '0;
            ctx_q.st <= ST_IDLE;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    // Bus outputs
    logic first_slot;
    assign first_slot = (ctx_q.st == ST_RD1) || (ctx_q.st == ST_WR1);

    always_comb begin
        bus_req_o  = (ctx_q.st == ST_RD1) || (ctx_q.st == ST_RD2) ||
                     (ctx_q.st == ST_WR1) || (ctx_q.st == ST_WR2);
        bus_we_o   = (ctx_q.st == ST_WR1) || (ctx_q.st == ST_WR2);
        bus_size_o = ctx_q.fused ? SZ_DBL : (ctx_q.lng ? SZ_WORD : SZ_HALF);
        if (ctx_q.fused)     bus_addr_o = ctx_q.swap ? ctx_q.a2 : ctx_q.a1;
        else if (first_slot) bus_addr_o = ctx_q.a1;
        else                 bus_addr_o = ctx_q.a2;
        if (ctx_q.fused)
            bus_wdata_o = ctx_q.swap ? {ctx_q.u2, ctx_q.u1} : {ctx_q.u1, ctx_q.u2};
        else
            bus_wdata_o = {32'h0, fit(first_slot ? ctx_q.u1 : ctx_q.u2, ctx_q.lng)};
    end

    // Flags: first differing pair, else pair B
    logic        pick_a;
    logic [31:0] fl_m, fl_c;
    assign pick_a = (fit(ctx_q.m1, ctx_q.lng) != fit(ctx_q.c1, ctx_q.lng));
    assign fl_m   = pick_a ? ctx_q.m1 : ctx_q.m2;
    assign fl_c   = pick_a ? ctx_q.c1 : ctx_q.c2;

    dcas_flag_calc u_flags (
        .mem_i (fl_m),
        .cmp_i (fl_c),
        .long_i(ctx_q.lng),
        .nzvc_o(flags_o)
    );

    // Final-state write-back
    always_comb begin
        done_o     = (ctx_q.st == ST_FIN);
        wb1_en_o   = done_o;
        wb2_en_o   = done_o;
        wb1_idx_o  = ctx_q.ic1;
        wb2_idx_o  = ctx_q.ic2;
        wb1_data_o = ctx_q.lng ? ctx_q.m1 : {ctx_q.c1[31:16], ctx_q.m1[15:0]};
        wb2_data_o = ctx_q.lng ? ctx_q.m2 : {ctx_q.c2[31:16], ctx_q.m2[15:0]};
    end
endmodule

// File: rtl/dcas_seq_chk.sv
module dcas_seq_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_req_o,
    input logic          bus_we_o,
    input logic [1:0]    bus_size_o,
    input logic [AW-1:0] bus_addr_o,
    input logic          bus_ack_i,
    input logic          wb1_en_o,
    input logic          wb2_en_o,
    input logic          done_o,
    input logic [3:0]    flags_o
);
    logic [1:0] rd_cnt, wr_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_cnt <= 2'd0;
            wr_cnt <= 2'd0;
        end else if (done_o) begin
            rd_cnt <= 2'd0;
            wr_cnt <= 2'd0;
        end else if (bus_req_o && bus_ack_i) begin
            if (bus_we_o) wr_cnt <= wr_cnt + 2'd1;
            else          rd_cnt <= rd_cnt + 2'd1;
        end
    end

    a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) &&
                                    $stable(bus_we_o) && $stable(bus_size_o));

    a_r2_reads_first: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o && bus_we_o |-> (bus_size_o == 2'd2) ? (rd_cnt == 2'd1) : (rd_cnt == 2'd2));

    a_r2_write_iff_match: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> flags_o[2] == (wr_cnt != 2'd0));

    a_r8_final_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !bus_req_o && wb1_en_o && wb2_en_o);

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r6_dbl_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o && bus_size_o == 2'd2 |-> bus_addr_o[2:0] == 3'b000);
endmodule

bind dcas_seq dcas_seq_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req_o (bus_req_o),
    .bus_we_o  (bus_we_o),
    .bus_size_o(bus_size_o),
    .bus_addr_o(bus_addr_o),
    .bus_ack_i (bus_ack_i),
    .wb1_en_o  (wb1_en_o),
    .wb2_en_o  (wb2_en_o),
    .done_o    (done_o),
    .flags_o   (flags_o)
);

// File: tb/dcas_seq_bench.sv
module dcas_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        long_i = 1'b0;
    logic [31:0] addr1_i = '0, addr2_i = '0;
    logic [11:0] sel_i = '0;
    logic [255:0] rf_flat;
    logic        bus_req_o, bus_we_o, bus_ack_i = 1'b0;
    logic [1:0]  bus_size_o;
    logic [31:0] bus_addr_o;
    logic [63:0] bus_wdata_o, bus_rdata_i = '0;
    logic        wb1_en_o, wb2_en_o, done_o;
    logic [2:0]  wb1_idx_o, wb2_idx_o;
    logic [31:0] wb1_data_o, wb2_data_o;
    logic [3:0]  flags_o;

    int tests = 0, fails = 0;
    int n_acc = 0, n_dbl = 0;
    logic [7:0]  mem [256];
    logic [31:0] rf [8];

    always #2 clk = ~clk;

    always_comb for (int i = 0; i < 8; i++) rf_flat[i*32 +: 32] = rf[i];

    dcas_seq u_dcas_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .long_i(long_i),
        .addr1_i(addr1_i), .addr2_i(addr2_i), .sel_i(sel_i), .rf_i(rf_flat),
        .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_size_o(bus_size_o),
        .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i),
        .bus_rdata_i(bus_rdata_i),
        .wb1_en_o(wb1_en_o), .wb1_idx_o(wb1_idx_o), .wb1_data_o(wb1_data_o),
        .wb2_en_o(wb2_en_o), .wb2_idx_o(wb2_idx_o), .wb2_data_o(wb2_data_o),
        .done_o(done_o), .flags_o(flags_o)
    );

    function automatic logic [63:0] get_mem(input logic [31:0] a, input int nb);
        logic [63:0] v = '0;
        for (int i = 0; i < nb; i++) v = {v[55:0], mem[(a + i) & 32'hFF]};
        return v;
    endfunction

    task automatic put_mem(input logic [31:0] a, input logic [31:0] v, input int nb);
        for (int i = 0; i < nb; i++) mem[(a + i) & 32'hFF] = v[8*(nb-1-i) +: 8];
    endtask

    // Bus responder: R7 size codes 0/1/2 -> 2/4/8 bytes, big-endian, right-aligned
    initial begin
        forever begin
            @(negedge clk);
            if (bus_ack_i) bus_ack_i = 1'b0;
            else if (bus_req_o) begin
                int nb;
                nb = 2 << bus_size_o;
                n_acc++;
                if (bus_size_o == 2'd2) n_dbl++;
                if (bus_we_o) begin
                    for (int i = 0; i < nb; i++)
                        mem[(bus_addr_o + i) & 32'hFF] = bus_wdata_o[8*(nb-1-i) +: 8];
                end else begin
                    bus_rdata_i = get_mem(bus_addr_o, nb);
                end
                bus_ack_i = 1'b1;
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp,
                       input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] ref_flags(input logic [31:0] m, input logic [31:0] c,
                                             input logic lng);
        longint sm, sc, r;
        logic [31:0] t;
        logic n, z, v, b;
        int w;
        w = lng ? 32 : 16;
        if (lng) begin sm = longint'($signed(m)); sc = longint'($signed(c)); end
        else begin sm = longint'($signed(m[15:0])); sc = longint'($signed(c[15:0])); end
        r = sm - sc;
        t = m - c;
        if (!lng) t = {16'h0, t[15:0]};
        n = t[w-1];
        z = (t == 32'h0);
        v = lng ? (r > 64'sd2147483647 || r < -64'sd2147483648)
                : (r > 64'sd32767 || r < -64'sd32768);
        b = lng ? (m < c) : (m[15:0] < c[15:0]);
        return {n, z, v, b};
    endfunction

    // One complete operation with model-based checks
    task automatic run_op(input string tag, input logic [31:0] a1, input logic [31:0] a2,
                          input logic [11:0] sel, input logic lng, input bit poke,
                          input int exp_acc, input int exp_dbl);
        logic [31:0] m1, m2, c1, c2, u1, u2, cm1, cm2, exp_rf [8], exp1, exp2;
        logic [3:0]  exp_fl, got_fl;
        bit match, seen;
        int nb;
        nb = lng ? 4 : 2;
        m1 = get_mem(a1, nb); m2 = get_mem(a2, nb);
        c1 = rf[sel[11:9]]; c2 = rf[sel[8:6]]; u1 = rf[sel[5:3]]; u2 = rf[sel[2:0]];
        cm1 = lng ? c1 : {16'h0, c1[15:0]};
        cm2 = lng ? c2 : {16'h0, c2[15:0]};
        match = (m1 == cm1) && (m2 == cm2);
        exp1 = match ? (lng ? u1 : {16'h0, u1[15:0]}) : m1;
        exp2 = match ? (lng ? u2 : {16'h0, u2[15:0]}) : m2;
        for (int i = 0; i < 8; i++) exp_rf[i] = rf[i];
        exp_rf[sel[11:9]] = lng ? m1 : {c1[31:16], m1[15:0]};
        exp_rf[sel[8:6]]  = lng ? m2 : {c2[31:16], m2[15:0]};
        exp_fl = (m1 != cm1) ? ref_flags(m1, c1, lng) : ref_flags(m2, c2, lng);
        n_acc = 0; n_dbl = 0; seen = 0; got_fl = 4'h0;
        @(negedge clk);
        addr1_i = a1; addr2_i = a2; sel_i = sel; long_i = lng; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 200 && !seen; k++) begin
            if (done_o) begin
                seen = 1;
                got_fl = flags_o;
                chk("R8", {63'h0, bus_req_o}, 64'h0, {tag, " no request in final cycle"});
                if (wb1_en_o) rf[wb1_idx_o] = wb1_data_o;
                if (wb2_en_o) rf[wb2_idx_o] = wb2_data_o;
            end else begin
                if (poke && k == 1) begin
                    start_i = 1'b1; addr1_i = 32'hF0; addr2_i = 32'hE0; sel_i = 12'hFFF;
                end else start_i = 1'b0;
                @(negedge clk);
            end
        end
        start_i = 1'b0;
        chk("R8", {63'h0, seen}, 64'h1, {tag, " done seen"});
        if (!seen) return;
        @(negedge clk);
        chk("R5", {60'h0, got_fl}, {60'h0, exp_fl}, {tag, " flags NZVC"});
        chk("R2", get_mem(a1, nb), {32'h0, exp1}, {tag, " location A"});
        chk("R2", get_mem(a2, nb), {32'h0, exp2}, {tag, " location B"});
        for (int i = 0; i < 8; i++)
            chk("R3", {32'h0, rf[i]}, {32'h0, exp_rf[i]}, $sformatf("%s reg %0d", tag, i));
        chk("R6", n_acc, exp_acc, {tag, " access count"});
        chk("R6", n_dbl, exp_dbl, {tag, " 64-bit access count"});
        chk("R8", {63'h0, done_o}, 64'h0, {tag, " done one cycle"});
    endtask

    task automatic t_reset();
        chk("R9", {63'h0, bus_req_o}, 64'h0, "reset request");
        chk("R9", {63'h0, done_o}, 64'h0, "reset done");
        chk("R9", {62'h0, wb1_en_o, wb2_en_o}, 64'h0, "reset write-back");
    endtask

    task automatic t_long_ok(); // R1 R2 R3: separate locations, both match
        rf[1] = 32'h1111_2222; rf[2] = 32'h3333_4444; rf[3] = 32'hAAAA_0001; rf[4] = 32'hBBBB_0002;
        put_mem(32'h10, 32'h1111_2222, 4); put_mem(32'h40, 32'h3333_4444, 4);
        run_op("long_ok", 32'h10, 32'h40, {3'd1, 3'd2, 3'd3, 3'd4}, 1'b1, 0, 4, 0);
    endtask

    task automatic t_long_fail_a(); // R5: pair A differs, signed overflow
        rf[1] = 32'h0000_0001; rf[2] = 32'h5555_5555; rf[3] = 32'h1; rf[4] = 32'h2;
        put_mem(32'h20, 32'h8000_0000, 4); put_mem(32'h50, 32'h5555_5555, 4);
        run_op("fail_a", 32'h20, 32'h50, {3'd1, 3'd2, 3'd3, 3'd4}, 1'b1, 0, 2, 0);
    endtask

    task automatic t_long_fail_b(); // R5: pair A equal, pair B borrows
        rf[6] = 32'h0BAD_F00D; rf[7] = 32'h0000_0002; rf[0] = 32'h9; rf[5] = 32'h8;
        put_mem(32'h24, 32'h0BAD_F00D, 4); put_mem(32'h60, 32'h0000_0001, 4);
        run_op("fail_b", 32'h24, 32'h60, {3'd6, 3'd7, 3'd0, 3'd5}, 1'b1, 0, 2, 0);
    endtask

    task automatic t_word(); // R4: 16-bit success then failure, upper halves kept
        rf[5] = 32'hABCD_1234; rf[6] = 32'hABCD_5678; rf[7] = 32'hFFFF_0A0A; rf[0] = 32'hEEEE_0B0B;
        put_mem(32'h30, 32'h1234, 2); put_mem(32'h70, 32'h5678, 2);
        run_op("word_ok", 32'h30, 32'h70, {3'd5, 3'd6, 3'd7, 3'd0}, 1'b0, 0, 4, 0);
        rf[5] = 32'h7777_0A0A; rf[6] = 32'h6666_0001;
        put_mem(32'h70, 32'h8000, 2);
        run_op("word_fail", 32'h30, 32'h70, {3'd5, 3'd6, 3'd7, 3'd0}, 1'b0, 0, 2, 0);
    endtask

    task automatic t_fused(); // R6: aligned adjacent pair, success
        rf[1] = 32'hCAFE_0001; rf[2] = 32'hCAFE_0002; rf[3] = 32'h1234_5678; rf[4] = 32'h9ABC_DEF0;
        put_mem(32'h80, 32'hCAFE_0001, 4); put_mem(32'h84, 32'hCAFE_0002, 4);
        run_op("fused", 32'h80, 32'h84, {3'd1, 3'd2, 3'd3, 3'd4}, 1'b1, 0, 2, 2);
    endtask

    task automatic t_fused_mirror(); // R6: B is the aligned word, mismatch
        rf[1] = 32'h0000_0010; rf[2] = 32'h0000_0020; rf[3] = 32'h3; rf[4] = 32'h4;
        put_mem(32'h88, 32'h0000_0020, 4); put_mem(32'h8C, 32'h0000_0011, 4);
        run_op("mirror", 32'h8C, 32'h88, {3'd1, 3'd2, 3'd3, 3'd4}, 1'b1, 0, 1, 1);
    endtask

    task automatic t_unaligned_adj(); // R6: adjacent but not 8-aligned -> four accesses
        rf[1] = 32'h0101_0101; rf[2] = 32'h0202_0202; rf[3] = 32'h0303_0303; rf[4] = 32'h0404_0404;
        put_mem(32'h94, 32'h0101_0101, 4); put_mem(32'h98, 32'h0202_0202, 4);
        run_op("unaligned", 32'h94, 32'h98, {3'd1, 3'd2, 3'd3, 3'd4}, 1'b1, 0, 4, 0);
    endtask

    task automatic t_same_cmp(); // R3: equal compare indices, port 2 wins
        rf[5] = 32'h1357_9BDF; rf[3] = 32'h1; rf[4] = 32'h2;
        put_mem(32'hA0, 32'h2468_ACE0, 4); put_mem(32'hB0, 32'h0F0F_0F0F, 4);
        run_op("same_cmp", 32'hA0, 32'hB0, {3'd5, 3'd5, 3'd3, 3'd4}, 1'b1, 0, 2, 0);
    endtask

    task automatic t_busy_start(); // R8: start while busy ignored
        rf[1] = 32'h4444_0000; rf[2] = 32'h5555_0000; rf[3] = 32'h6; rf[4] = 32'h7;
        put_mem(32'hC0, 32'h4444_0000, 4); put_mem(32'hD0, 32'h5555_0000, 4);
        put_mem(32'hF0, 32'h0, 4); put_mem(32'hE0, 32'h0, 4);
        run_op("busy", 32'hC0, 32'hD0, {3'd1, 3'd2, 3'd3, 3'd4}, 1'b1, 1, 4, 0);
        chk("R8", get_mem(32'hF0, 4), 64'h0, "busy stray location untouched");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        for (int i = 0; i < 8; i++) rf[i] = 32'h0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_long_ok();
        t_long_fail_a();
        t_long_fail_b();
        t_word();
        t_fused();
        t_fused_mirror();
        t_unaligned_adj();
        t_same_cmp();
        t_busy_start();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #400000;
        tests++; fails++;
        $display("FAIL R8 watchdog: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule